// File: doc/BRIEF.md
# Bridge legacy I/O forwarding decoder

This block holds the control register of a virtual root-port bridge and decides, for every I/O access issued by the processor, whether that access is sent on to the secondary port. The register is read and written through a simple register port. Only four of its sixteen bits can be written. The two address bounds of the bridge's I/O window come in as inputs.

The decision combines several rules. An address first has to fall inside the inclusive base/limit window. If ISA exclusion is on, window addresses in the upper three quarters of each 1 KB block are then dropped. If VGA decoding is on, the legacy VGA I/O ports are forwarded whatever the window and the exclusion say. These ports are matched on either the low ten address bits or all sixteen. One control bit drives a hot-reset request toward the port's link state machine for as long as it stays set.

Top module: `io_fwd_bridge_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, `hot_rst_req` is low and `fwd_vld` is low.
- R2: Bits 15:7 other than bit 6, and bit 5, together with bits 1:0, always read 0, and writing 1 to them has no effect.
- R3: Bits 6, 4, 3 and 2 store the value written and hold it until the next write. A write of 0xFFFF reads back as 0x005C.
- R4: With bit 2 (ISA exclusion) clear, every address with `io_base` <= address <= `io_limit` is forwarded, and both ends are included.
- R5: With bit 2 set, a window address whose bits [9:8] are not 00 is not forwarded. A window address whose bits [9:8] are 00 is still forwarded.
- R6: An address outside the window is not forwarded unless it is a VGA match.
- R7: With bit 3 (VGA enable) set and bit 4 clear, an address is a VGA match when its bits [9:0] fall in 0x3B0–0x3BB or 0x3C0–0x3DF. A match is forwarded even when it lies outside the window or is dropped by ISA exclusion.
- R8: With bits 3 and 4 both set, an address is a VGA match only when all 16 bits fall in those ranges, so aliases such as 0x7C5 are not matched.
- R9: Bit 4 has no effect while bit 3 is clear.
- R10: `hot_rst_req` equals bit 6 of the register. It rises in the cycle after a write that sets the bit and falls in the cycle after a write that clears it.
- R11: Every access sampled with `io_vld` high produces exactly one result on the next cycle: `fwd_vld` is high and `fwd_take` gives the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| io_base | input | 16 | Lowest forwarded I/O address (inclusive) |
| io_limit | input | 16 | Highest forwarded I/O address (inclusive) |
| io_vld | input | 1 | Processor I/O access present |
| io_addr | input | 16 | I/O address of the access |
| fwd_vld | output | 1 | Decision valid, one cycle after the access |
| fwd_take | output | 1 | 1 = forward to secondary port |
| hot_rst_req | output | 1 | Hot-reset request to link state machine |

## Verification
The hardest case to reach is an address that two rules judge in opposite ways. One example is 0x13C0 with a window of 0x1000–0x1FFF and both ISA exclusion and 10-bit VGA decoding on. ISA exclusion drops it, but its low ten bits hit a VGA port, so it must be forwarded. The stimulus reprograms the control register between bursts of accesses, so each burst holds a different mix of enables. Every access is placed on purpose: on the window edges, on the 1 KB block boundaries, on the VGA range edges and on their 1 KB aliases. A scoreboard checks each burst's results in order.

// File: rtl/io_fwd_bridge_ctrl.sv
module io_fwd_bridge_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [DW-1:0] WR_MASK = 16'h005C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [AW-1:0] io_base,
  input  logic [AW-1:0] io_limit,
  input  logic          io_vld,
  input  logic [AW-1:0] io_addr,
  output logic          fwd_vld,
  output logic          fwd_take,
  output logic          hot_rst_req
);
  localparam int BLK_W = 10;

  logic [DW-1:0] ctrl_q;
  logic isa_on, vga_on, vga_wide;
  logic [AW-1:0] vga_a;
  logic in_win, isa_drop, vga_hit, take_d;

  assign isa_on   = ctrl_q[2];
  assign vga_on   = ctrl_q[3];
  assign vga_wide = ctrl_q[4];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_wr) ctrl_q <= reg_wdata & WR_MASK;
  end

  assign reg_rdata   = ctrl_q;
  assign hot_rst_req = ctrl_q[6];

  assign vga_a    = vga_wide ? io_addr : {{(AW-BLK_W){1'b0}}, io_addr[BLK_W-1:0]};
  assign vga_hit  = vga_on && (((vga_a >= AW'('h3B0)) && (vga_a <= AW'('h3BB))) ||
                               ((vga_a >= AW'('h3C0)) && (vga_a <= AW'('h3DF))));
  assign in_win   = (io_addr >= io_base) && (io_addr <= io_limit);
  assign isa_drop = isa_on && (io_addr[BLK_W-1:BLK_W-2] != 2'b00);
  assign take_d   = vga_hit || (in_win && !isa_drop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_vld  <= 1'b0;
      fwd_take <= 1'b0;
    end else begin
      fwd_vld  <= io_vld;
      fwd_take <= io_vld && take_d;
    end
  end

  // register behaviour
  p_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata == ($past(reg_wdata) & 16'h005C));
  p_ro_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata & 16'hFFA3) == 16'h0000);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(reg_rdata));
  p_hot_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hot_rst_req) |-> $past(reg_wr) && $past(reg_wdata[6]));

  // forwarding decision
  p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    io_vld |=> fwd_vld);
  p_no_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_vld |=> !fwd_vld && !fwd_take);
  p_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_vld && !vga_on && ((io_addr < io_base) || (io_addr > io_limit)) |=> !fwd_take);
  p_isa_r5: assert property (@(posedge clk) disable iff (!rst_n)
    io_vld && !vga_on && isa_on && (io_addr[9:8] != 2'b00) |=> !fwd_take);
  p_plain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_vld && !isa_on && (io_addr >= io_base) && (io_addr <= io_limit) |=> fwd_take);
endmodule

// File: tb/sim_io_fwd_bridge_ctrl.sv
module sim_io_fwd_bridge_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] io_base = 16'h1000;
  logic [15:0] io_limit = 16'h1FFF;
  logic io_vld = 1'b0;
  logic [15:0] io_addr = '0;
  logic fwd_vld, fwd_take, hot_rst_req;

  int n_run = 0;
  int n_fail = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [15:0] ctrl_m = '0;

  always #10 clk = ~clk;

  io_fwd_bridge_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .io_base(io_base), .io_limit(io_limit),
    .io_vld(io_vld), .io_addr(io_addr), .fwd_vld(fwd_vld),
    .fwd_take(fwd_take), .hot_rst_req(hot_rst_req));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit model(logic [15:0] a);
    logic [15:0] v;
    bit vga, win;
    v = ctrl_m[4] ? a : {6'b0, a[9:0]};
    vga = ctrl_m[3] && ((v >= 16'h3B0 && v <= 16'h3BB) || (v >= 16'h3C0 && v <= 16'h3DF));
    win = (a >= io_base) && (a <= io_limit);
    return vga || (win && !(ctrl_m[2] && a[9:8] != 2'b00));
  endfunction

  task automatic wr_ctrl(logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    ctrl_m = d & 16'h005C;
  endtask

  task automatic send(string tag, logic [15:0] a);
    @(negedge clk);
    io_vld = 1'b1; io_addr = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    io_vld = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops one expectation per result
  always @(negedge clk) begin
    if (rst_n && fwd_vld) begin
      if (exp_q.size() == 0) check("R11 unexpected result", 16'(fwd_vld), 16'h0);
      else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, 16'(fwd_take), 16'(e));
      end
    end
  end

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset reg", reg_rdata, 16'h0000);
    check("R1 reset hot", 16'(hot_rst_req), 16'h0);
    check("R1 reset vld", 16'(fwd_vld), 16'h0);

    wr_ctrl(16'hFFFF);
    check("R2 R3 mask readback", reg_rdata, 16'h005C);
    check("R10 hot set", 16'(hot_rst_req), 16'h1);
    wr_ctrl(16'hFFA3);
    check("R2 ro bits ignored", reg_rdata, 16'h0000);
    check("R10 hot clear", 16'(hot_rst_req), 16'h0);
    wr_ctrl(16'h0014);
    repeat (3) @(negedge clk);
    check("R3 hold", reg_rdata, 16'h0014);
    wr_ctrl(16'h0000);

    // R4 / R6 / R11: plain window, back-to-back
    send("R4 base", 16'h1000);
    send("R4 limit", 16'h1FFF);
    send("R6 below", 16'h0FFF);
    send("R6 above", 16'h2000);
    send("R4 mid upper quarter", 16'h1100);
    idle();
    // R5 ISA exclusion
    wr_ctrl(16'h0004);
    send("R5 low quarter", 16'h1000);
    send("R5 low quarter end", 16'h10FF);
    send("R5 upper start", 16'h1100);
    send("R5 upper end", 16'h13FF);
    send("R5 next block", 16'h1400);
    send("R6 isa outside", 16'h0800);
    idle();
    // R7 10-bit VGA
    wr_ctrl(16'h0008);
    send("R7 3B0 outside window", 16'h03B0);
    send("R7 3BB", 16'h03BB);
    send("R7 3BC gap", 16'h03BC);
    send("R7 alias 7C5", 16'h07C5);
    send("R7 3DF", 16'h03DF);
    send("R7 3E0", 16'h03E0);
    idle();
    // R8 16-bit VGA
    wr_ctrl(16'h0018);
    send("R8 alias 7C5", 16'h07C5);
    send("R8 exact 3C5", 16'h03C5);
    send("R8 alias 3B0+400", 16'h07B0);
    idle();
    // R9 wide bit alone
    wr_ctrl(16'h0010);
    send("R9 3C5 no vga", 16'h03C5);
    send("R9 window still", 16'h1200);
    idle();
    // R7 VGA overrides ISA drop
    wr_ctrl(16'h000C);
    send("R7 vga beats isa", 16'h13C0);
    send("R5 isa drop non-vga", 16'h1380);
    idle();
    // R4 single-address window
    io_base = 16'h1234; io_limit = 16'h1234;
    wr_ctrl(16'h0000);
    send("R4 single hit", 16'h1234);
    send("R4 single below", 16'h1233);
    send("R4 single above", 16'h1235);
    idle();
    check("R11 all results seen", 16'(exp_q.size()), 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule